// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block keeps a small, fully associative set of recent page translations and searches all of them on every memory reference. Each entry records the owning process identifier, a virtual page number, a physical frame number and three access-right bits (read, write, execute). A reference carries a process identifier, a virtual address and an access kind. One cycle later the block reports a hit with the physical address, a miss, or an access violation.

Two maintenance paths run alongside the lookup. The first is a fill path. After an external page-table walk it installs a translation. It overwrites an entry that already holds the same process and page, or else takes a free slot, or else evicts a victim in rotating order. The second is a flush path. It drops every translation, or only those of one process, in a single cycle. The walk and fault handling sit outside this block.

Top module: `ptag_tlb`

## Requirements
- R1: After reset every entry is invalid and `rs_valid` is low, so the first lookup reports a miss (`rs_status` = 0).
- R2: A lookup presented with `lk_valid` high gives exactly one result with `rs_valid` high on the next clock edge. No result appears in a cycle that follows one without a lookup.
- R3: A lookup hits only when a valid entry matches both the page number (`lk_vaddr[31:12]`) and `lk_pid`, and the entry grants the access. On a hit `rs_status` = 1 and `rs_paddr` = {frame, `lk_vaddr[11:0]`}.
- R4: An entry that matches the page number but holds a different process identifier never produces a hit. The lookup reports a miss.
- R5: Permission bits are bit 0 = read, bit 1 = write and bit 2 = execute. Access kind 0 is a read, 1 a write and 2 an execute fetch; any other code is checked as a read. A matching entry whose required bit is clear gives `rs_status` = 2 and `rs_paddr` = 0. On a miss `rs_paddr` is also 0.
- R6: A fill with no matching entry goes to the lowest-numbered invalid entry. Eight distinct fills after reset are all retained.
- R7: When all entries are valid, a fill with no match replaces the entry chosen by a rotating pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, on each such replacement only.
- R8: A fill whose process identifier and page number match a valid entry rewrites that entry's frame and permissions in place. No other entry is evicted, and no two valid entries ever share a process and page.
- R9: A flush with `fs_pid_en` high invalidates, in one cycle, only the entries whose process identifier equals `fs_pid`.
- R10: A flush with `fs_all` high invalidates every entry in one cycle.
- R11: When a flush and a fill occur in the same cycle, the flush is applied first and the filled entry remains valid afterwards.
- R12: A lookup in the same cycle as a fill is judged against the contents before that fill. The new translation is visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pid | input | 8 | Process identifier of the reference |
| lk_vaddr | input | 32 | Virtual address (page number and offset) |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| fl_valid | input | 1 | Install a translation |
| fl_pid | input | 8 | Process identifier of the new entry |
| fl_vpn | input | 20 | Virtual page number of the new entry |
| fl_pfn | input | 20 | Frame number of the new entry |
| fl_perm | input | 3 | Access rights {execute, write, read} |
| fs_all | input | 1 | Invalidate all entries |
| fs_pid_en | input | 1 | Invalidate entries of one process |
| fs_pid | input | 8 | Process identifier for the selective flush |
| rs_valid | output | 1 | Lookup result valid |
| rs_status | output | 2 | 0 miss, 1 hit, 2 access violation |
| rs_paddr | output | 32 | Physical address on a hit, else 0 |

## Verification
Three paths can act in the same cycle: a lookup, a fill and a flush. The bench drives a lookup of a page in the very cycle its fill is issued and expects a miss, then a hit one cycle later. It also pairs a global flush with a fill and expects only the filled page to survive. Every lookup result is predicted by a behavioural model of the requirements, which takes the lookup against the old contents and then applies flush before fill. The result is compared by a scoreboard when the design produces it.

// File: rtl/ptag_tlb_pkg.sv
package ptag_tlb_pkg;
    parameter int ENTRIES = 8;
    parameter int VPN_W   = 20;
    parameter int PFN_W   = 20;
    parameter int PID_W   = 8;
    parameter int OFS_W   = 12;
    parameter int PERM_W  = 3;
    parameter int IDX_W   = $clog2(ENTRIES);
    parameter int VA_W    = VPN_W + OFS_W;
    parameter int PA_W    = PFN_W + OFS_W;

    parameter int PERM_R = 0;
    parameter int PERM_W_BIT = 1;
    parameter int PERM_X = 2;

    parameter logic [1:0] KIND_READ  = 2'd0;
    parameter logic [1:0] KIND_WRITE = 2'd1;
    parameter logic [1:0] KIND_EXEC  = 2'd2;

    typedef enum logic [1:0] {
        RS_MISS  = 2'd0,
        RS_HIT   = 2'd1,
        RS_FAULT = 2'd2
    } rs_e;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][PID_W-1:0]  pid;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][PFN_W-1:0]  pfn;
        logic [ENTRIES-1:0][PERM_W-1:0] perm;
        logic [IDX_W-1:0]               rr;
        logic                           rs_valid;
        rs_e                            rs_status;
        logic [PA_W-1:0]                rs_paddr;
    } state_t;
endpackage

// File: rtl/ptag_tlb_cam.sv
module ptag_tlb_cam #(
    parameter int N    = 8,
    parameter int PIDW = 8,
    parameter int VPNW = 20
) (
    input  logic [N-1:0]           valid,
    input  logic [N-1:0][PIDW-1:0] pid,
    input  logic [N-1:0][VPNW-1:0] vpn,
    input  logic [PIDW-1:0]        key_pid,
    input  logic [VPNW-1:0]        key_vpn,
    output logic [N-1:0]           match
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = valid[i] && (pid[i] == key_pid) && (vpn[i] == key_vpn);
    end
endmodule

// File: rtl/ptag_tlb_victim.sv
module ptag_tlb_victim #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  valid,
    input  logic [N-1:0]  match,
    input  logic [IW-1:0] rr,
    output logic [IW-1:0] idx,
    output logic          adv_rr
);
    always_comb begin
        idx    = '0;
        adv_rr = 1'b0;
        if (|match) begin
            for (int i = 0; i < N; i++) begin
                if (match[i]) idx = IW'(i);
            end
        end else if (!(&valid)) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (!valid[i]) idx = IW'(i);
            end
        end else begin
            idx    = rr;
            adv_rr = 1'b1;
        end
    end
endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb
    import ptag_tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [1:0]        lk_kind,
    input  logic              fl_valid,
    input  logic [PID_W-1:0]  fl_pid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [PFN_W-1:0]  fl_pfn,
    input  logic [PERM_W-1:0] fl_perm,
    input  logic              fs_all,
    input  logic              fs_pid_en,
    input  logic [PID_W-1:0]  fs_pid,
    output logic              rs_valid,
    output logic [1:0]        rs_status,
    output logic [PA_W-1:0]   rs_paddr
);
    state_t s_q, s_d;

    logic [ENTRIES-1:0] lk_match;
    logic [ENTRIES-1:0] fl_match;
    logic [ENTRIES-1:0] fs_match;
    logic [IDX_W-1:0]   fl_idx;
    logic               fl_adv;

    ptag_tlb_cam #(.N(ENTRIES), .PIDW(PID_W), .VPNW(VPN_W)) u_lk_cam (
        .valid(s_q.valid), .pid(s_q.pid), .vpn(s_q.vpn),
        .key_pid(lk_pid), .key_vpn(lk_vaddr[VA_W-1:OFS_W]), .match(lk_match)
    );

    ptag_tlb_cam #(.N(ENTRIES), .PIDW(PID_W), .VPNW(VPN_W)) u_fl_cam (
        .valid(s_q.valid), .pid(s_q.pid), .vpn(s_q.vpn),
        .key_pid(fl_pid), .key_vpn(fl_vpn), .match(fl_match)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_fs
        assign fs_match[i] = s_q.valid[i] && (s_q.pid[i] == fs_pid);
    end

    ptag_tlb_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
        .valid(s_q.valid), .match(fl_match), .rr(s_q.rr),
        .idx(fl_idx), .adv_rr(fl_adv)
    );

    logic [PFN_W-1:0]  sel_pfn;
    logic [PERM_W-1:0] sel_perm;
    logic              need_ok;

    always_comb begin
        sel_pfn  = '0;
        sel_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel_pfn  = sel_pfn  | ({PFN_W{lk_match[i]}}  & s_q.pfn[i]);
            sel_perm = sel_perm | ({PERM_W{lk_match[i]}} & s_q.perm[i]);
        end
        case (lk_kind)
            KIND_WRITE: need_ok = sel_perm[PERM_W_BIT];
            KIND_EXEC:  need_ok = sel_perm[PERM_X];
            default:    need_ok = sel_perm[PERM_R];
        endcase
    end

    always_comb begin
        s_d = s_q;
        // lookup result, judged on the contents before this cycle's updates
        s_d.rs_valid  = lk_valid;
        s_d.rs_status = RS_MISS;
        s_d.rs_paddr  = '0;
        if (lk_valid && (|lk_match)) begin
            if (need_ok) begin
                s_d.rs_status = RS_HIT;
                s_d.rs_paddr  = {sel_pfn, lk_vaddr[OFS_W-1:0]};
            end else begin
                s_d.rs_status = RS_FAULT;
            end
        end
        // flush first
        if (fs_all) begin
            s_d.valid = '0;
        end else if (fs_pid_en) begin
            s_d.valid = s_q.valid & ~fs_match;
        end
        // then fill
        if (fl_valid) begin
            s_d.valid[fl_idx] = 1'b1;
            s_d.pid[fl_idx]   = fl_pid;
            s_d.vpn[fl_idx]   = fl_vpn;
            s_d.pfn[fl_idx]   = fl_pfn;
            s_d.perm[fl_idx]  = fl_perm;
            if (fl_adv) begin
                s_d.rr = (s_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : s_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rs_valid  = s_q.rs_valid;
    assign rs_status = s_q.rs_status;
    assign rs_paddr  = s_q.rs_paddr;

    assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);
    assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);
    assert_hit_keeps_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (|lk_match) && need_ok) |=> (rs_status == RS_HIT) &&
        (rs_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])));
    assert_status_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (rs_status != 2'd3) && ((rs_status == RS_HIT) || (rs_paddr == '0)));
    assert_no_duplicate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match) && $onehot0(fl_match));
    assert_rr_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_valid |=> $stable(s_q.rr));
    assert_global_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_all && !fl_valid) |=> (s_q.valid == '0));
    assert_fill_survives_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |=> (s_q.valid != '0));
endmodule

// File: tb/ptag_tlb_test.sv
`timescale 1ns/1ps
module ptag_tlb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [7:0]  lk_pid = '0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = '0;
    logic        fl_valid = 1'b0;
    logic [7:0]  fl_pid = '0;
    logic [19:0] fl_vpn = '0;
    logic [19:0] fl_pfn = '0;
    logic [2:0]  fl_perm = '0;
    logic        fs_all = 1'b0;
    logic        fs_pid_en = 1'b0;
    logic [7:0]  fs_pid = '0;
    logic        rs_valid;
    logic [1:0]  rs_status;
    logic [31:0] rs_paddr;

    ptag_tlb uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pid(lk_pid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
        .fl_valid(fl_valid), .fl_pid(fl_pid), .fl_vpn(fl_vpn), .fl_pfn(fl_pfn), .fl_perm(fl_perm),
        .fs_all(fs_all), .fs_pid_en(fs_pid_en), .fs_pid(fs_pid),
        .rs_valid(rs_valid), .rs_status(rs_status), .rs_paddr(rs_paddr)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [1:0]  st;
        logic [31:0] pa;
        string       tag;
    } exp_t;
    exp_t sb[$];

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // behavioural model of the requirements
    bit          m_v[8];
    logic [7:0]  m_pid[8];
    logic [19:0] m_vpn[8];
    logic [19:0] m_pfn[8];
    logic [2:0]  m_perm[8];
    int          m_rr = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [7:0] pid, input logic [31:0] va,
                                     input logic [1:0] kind, input string tag);
        exp_t e;
        e.st = 2'd0; e.pa = '0; e.tag = tag;
        for (int i = 0; i < 8; i++) begin
            if (m_v[i] && m_pid[i] == pid && m_vpn[i] == va[31:12]) begin
                bit ok;
                ok = (kind == 2'd1) ? m_perm[i][1] : (kind == 2'd2) ? m_perm[i][2] : m_perm[i][0];
                if (ok) begin
                    e.st = 2'd1; e.pa = {m_pfn[i], va[11:0]};
                end else begin
                    e.st = 2'd2;
                end
            end
        end
        return e;
    endfunction

    task automatic model_update(input bit f_en, input logic [7:0] pid, input logic [19:0] vpn,
                                input logic [19:0] pfn, input logic [2:0] perm,
                                input bit all, input bit pen, input logic [7:0] fpid);
        int tgt;
        tgt = -1;
        if (f_en) begin
            for (int i = 0; i < 8; i++)
                if (m_v[i] && m_pid[i] == pid && m_vpn[i] == vpn) tgt = i;
            if (tgt < 0) for (int i = 7; i >= 0; i--) if (!m_v[i]) tgt = i;
            if (tgt < 0) begin
                tgt = m_rr;
                m_rr = (m_rr + 1) % 8;
            end
        end
        for (int i = 0; i < 8; i++) begin
            if (all) m_v[i] = 1'b0;
            else if (pen && m_pid[i] == fpid) m_v[i] = 1'b0;
        end
        if (f_en) begin
            m_v[tgt] = 1'b1; m_pid[tgt] = pid; m_vpn[tgt] = vpn;
            m_pfn[tgt] = pfn; m_perm[tgt] = perm;
        end
    endtask

    // driver: one cycle of stimulus, called at a falling edge
    task automatic step(input bit l_en, input logic [7:0] lpid, input logic [31:0] va,
                        input logic [1:0] kind, input string tag,
                        input bit f_en, input logic [7:0] fpid, input logic [19:0] vpn,
                        input logic [19:0] pfn, input logic [2:0] perm,
                        input bit all, input bit pen, input logic [7:0] xpid);
        lk_valid = l_en; lk_pid = lpid; lk_vaddr = va; lk_kind = kind;
        fl_valid = f_en; fl_pid = fpid; fl_vpn = vpn; fl_pfn = pfn; fl_perm = perm;
        fs_all = all; fs_pid_en = pen; fs_pid = xpid;
        if (l_en) sb.push_back(predict(lpid, va, kind, tag));
        model_update(f_en, fpid, vpn, pfn, perm, all, pen, xpid);
        @(negedge clk);
        lk_valid = 1'b0; fl_valid = 1'b0; fs_all = 1'b0; fs_pid_en = 1'b0;
    endtask

    task automatic look(input logic [7:0] pid, input logic [19:0] vpn, input logic [11:0] ofs,
                        input logic [1:0] kind, input string tag);
        step(1'b1, pid, {vpn, ofs}, kind, tag, 1'b0, '0, '0, '0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic fill(input logic [7:0] pid, input logic [19:0] vpn,
                        input logic [19:0] pfn, input logic [2:0] perm);
        step(1'b0, '0, '0, '0, "", 1'b1, pid, vpn, pfn, perm, 1'b0, 1'b0, '0);
    endtask

    // monitor: compares each result shortly after the edge that produced it
    always @(posedge clk) begin
        #1;
        if (rst_n && rs_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected result", 64'(rs_status), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rs_status == e.st, e.tag, "status", 64'(rs_status), 64'(e.st));
                check(rs_paddr == e.pa, e.tag, "paddr", 64'(rs_paddr), 64'(e.pa));
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", "timeout", 64'd0, 64'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_v[i] = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check(rs_valid == 1'b0, "R1", "rs_valid after reset", 64'(rs_valid), 64'd0);
        look(8'd1, 20'h00010, 12'h123, 2'd0, "R1");
        // same-cycle lookup and fill: old contents, then visible
        step(1'b1, 8'd1, {20'h00010, 12'h0AA}, 2'd0, "R12",
             1'b1, 8'd1, 20'h00010, 20'hABCDE, 3'b011, 1'b0, 1'b0, '0);
        look(8'd1, 20'h00010, 12'h0AA, 2'd0, "R12");
        look(8'd1, 20'h00010, 12'hFFF, 2'd1, "R3");
        look(8'd1, 20'h00010, 12'h001, 2'd2, "R5");
        look(8'd1, 20'h00010, 12'h002, 2'd3, "R5");
        look(8'd2, 20'h00010, 12'h004, 2'd0, "R4");
        // in-place overwrite
        fill(8'd1, 20'h00010, 20'h12345, 3'b001);
        look(8'd1, 20'h00010, 12'h777, 2'd0, "R8");
        look(8'd1, 20'h00010, 12'h778, 2'd1, "R5");
        // fill the rest of the entries
        for (int i = 0; i < 7; i++) fill(8'd2, 20'h00020 + 20'(i), 20'h00100 + 20'(i), 3'b111);
        look(8'd1, 20'h00010, 12'h010, 2'd0, "R6");
        for (int i = 0; i < 7; i++) look(8'd2, 20'h00020 + 20'(i), 12'h020, 2'd2, "R6");
        // rotating replacement
        fill(8'd3, 20'h00030, 20'h00300, 3'b111);
        look(8'd1, 20'h00010, 12'h030, 2'd0, "R7");
        look(8'd3, 20'h00030, 12'h031, 2'd1, "R7");
        fill(8'd3, 20'h00031, 20'h00301, 3'b101);
        look(8'd2, 20'h00020, 12'h032, 2'd0, "R7");
        look(8'd2, 20'h00021, 12'h033, 2'd0, "R7");
        look(8'd3, 20'h00031, 12'h034, 2'd1, "R5");
        // selective flush
        step(1'b0, '0, '0, '0, "", 1'b0, '0, '0, '0, '0, 1'b0, 1'b1, 8'd2);
        look(8'd2, 20'h00022, 12'h040, 2'd0, "R9");
        look(8'd3, 20'h00030, 12'h041, 2'd0, "R9");
        // fill after flush reuses freed slots, then flush+fill together
        fill(8'd5, 20'h00050, 20'h00500, 3'b111);
        look(8'd5, 20'h00050, 12'h050, 2'd0, "R6");
        step(1'b0, '0, '0, '0, "", 1'b1, 8'd4, 20'h00040, 20'h00400, 3'b111, 1'b1, 1'b0, '0);
        look(8'd4, 20'h00040, 12'h060, 2'd2, "R11");
        look(8'd3, 20'h00030, 12'h061, 2'd0, "R10");
        look(8'd5, 20'h00050, 12'h062, 2'd0, "R11");
        // plain global flush
        step(1'b0, '0, '0, '0, "", 1'b0, '0, '0, '0, '0, 1'b1, 1'b0, '0);
        look(8'd4, 20'h00040, 12'h070, 2'd0, "R10");
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2", "results outstanding", 64'(sb.size()), 64'd0);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule